// File: doc/BRIEF.md
# UART Transmit Line Break and Transceiver Direction Control

This block sits between a UART's transmit shifter and the serial pin. It passes the shifter's serial stream through to the TX line. When software asks for it, it replaces the stream with a continuous low level (a line break). A break requested in the middle of a character is deferred until that character has left the shifter, so no frame is cut short. The break is held for as long as the break register stays non-zero.

The block also drives the direction of an external transceiver. In full-duplex operation the driver is simply kept enabled. In half-duplex operation the transceiver is turned to transmit as soon as the shifter is busy or a break is driven. After the line falls quiet, the block waits a programmable number of bit times before it turns the transceiver back to receive. If new data starts during that wait, the countdown is dropped.

Software reaches two registers: an 8-bit break request register and a 4-bit turn-around delay. Both read back the last value written. The bit-time tick comes from the baud generator, which is outside this block.

Top module: `uart_tx_line_ctrl`

## Requirements
- R1: While `rst` is sampled high at a clock edge, the following cycle shows `txd`=1 and `xcvr_tx`=0 (receive), and both registers read back as zero.
- R2: A write to either register (write enable high at an edge) is visible on its read-back port from the next cycle on, and the register holds that value until the next write.
- R3: When the break register is non-zero and `sh_busy` is low at an edge, `txd` is 0 in the next cycle. It stays 0 at every later cycle while the register stays non-zero, including when `sh_busy` goes high again.
- R4: In the cycle after the break register is seen as zero, `txd` no longer carries the break: it is 1 if `sh_busy` was low and the sampled `sh_txd` if `sh_busy` was high.
- R5: A break requested while `sh_busy` is high does not alter `txd`. The line keeps following `sh_txd` until the first edge that sees `sh_busy` low, and it goes to 0 in the cycle after that edge.
- R6: Outside a break, `txd` is a registered copy of `sh_txd` when `sh_busy` is high and 1 when it is low, with one cycle of latency.
- R7: When `hdx_en` is low at an edge, `xcvr_tx` is 1 in the next cycle.
- R8: When `sh_busy` is high at an edge, `xcvr_tx` is 1 in the next cycle, whatever the mode.
- R9: In half-duplex mode with delay value D, counting starts at the first edge with the line idle (shifter not busy, no break). `xcvr_tx` turns to 0 after the edge that sees the (D+1)-th `bit_tick` at or after that point. With D=0 this is the first tick. `xcvr_tx` never falls after an edge without a tick.
- R10: If the shifter becomes busy during the turn-around countdown, `xcvr_tx` stays 1 and the count starts again from zero at the next idle period.
- R11: While a break is being driven in half-duplex mode, `xcvr_tx` stays 1.
- R12: If the delay register is lowered to a value at or below the number of ticks already counted, `xcvr_tx` turns to 0 after the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| brk_wr_en | input | 1 | Write strobe for the break register |
| brk_wr_data | input | 8 | Break register write value; any non-zero value requests a break |
| brk_rd_data | output | 8 | Break register read-back |
| dly_wr_en | input | 1 | Write strobe for the turn-around delay register |
| dly_wr_data | input | 4 | Turn-around delay in bit times |
| dly_rd_data | output | 4 | Delay register read-back |
| hdx_en | input | 1 | 1 = half-duplex direction control, 0 = driver always enabled |
| sh_busy | input | 1 | Transmit shifter is sending a character |
| sh_txd | input | 1 | Serial output of the transmit shifter |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| txd | output | 1 | Registered TX line |
| xcvr_tx | output | 1 | Transceiver direction: 1 = transmit, 0 = receive |

## Verification
The checker tests the one-cycle relations on every cycle: reset values, register read-back, break low after an idle request, release to idle or data, the pass-through of a character when a break arrives mid-frame, the forced transmit direction in full-duplex mode, while busy and during a break, and the rule that receive direction is only entered after a tick. The exact tick count of the turn-around, cancelling it when a new character starts, and lowering the delay during a countdown span many cycles. Only the bench scenarios show these, by matching its cycle model and by counting the ticks until the direction flips.

// File: rtl/uart_lc_pkg.sv
package uart_lc_pkg;
  typedef enum logic {
    DIR_RX = 1'b0,
    DIR_TX = 1'b1
  } xcvr_dir_e;

  localparam logic LINE_IDLE  = 1'b1;
  localparam logic LINE_BREAK = 1'b0;
endpackage

// File: rtl/uart_lc_regs.sv
module uart_lc_regs #(
  parameter int BRK_W = 8,
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             brk_we,
  input  logic [BRK_W-1:0] brk_wdata,
  input  logic             dly_we,
  input  logic [DLY_W-1:0] dly_wdata,
  output logic [BRK_W-1:0] brk_q,
  output logic [DLY_W-1:0] dly_q,
  output logic             brk_req
);
  always_ff @(posedge clk) begin
    if (rst) begin
      brk_q <= '0;
      dly_q <= '0;
    end else begin
      if (brk_we) brk_q <= brk_wdata;
      if (dly_we) dly_q <= dly_wdata;
    end
  end

  assign brk_req = |brk_q;
endmodule

// File: rtl/uart_lc_break.sv
module uart_lc_break
  import uart_lc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic brk_req,
  input  logic sh_busy,
  input  logic sh_txd,
  output logic brk_drive,
  output logic txd
);
  logic brk_on_q;

  // A break starts only at an edge where no character is in flight;
  // once running it is held until the request is withdrawn.
  assign brk_drive = brk_req & (brk_on_q | ~sh_busy);

  always_ff @(posedge clk) begin
    if (rst) begin
      brk_on_q <= 1'b0;
      txd      <= LINE_IDLE;
    end else begin
      brk_on_q <= brk_drive;
      if (brk_drive)    txd <= LINE_BREAK;
      else if (sh_busy) txd <= sh_txd;
      else              txd <= LINE_IDLE;
    end
  end
endmodule

// File: rtl/uart_lc_dir.sv
module uart_lc_dir
  import uart_lc_pkg::*;
#(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hdx_en,
  input  logic             line_active,
  input  logic             bit_tick,
  input  logic [DLY_W-1:0] dly,
  output logic             xcvr_tx
);
  xcvr_dir_e        dir_q;
  logic [DLY_W-1:0] cnt_q;
  logic             turn_done;

  // >= rather than == so a delay lowered below the count ends the wait.
  assign turn_done = (cnt_q >= dly);

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= DIR_RX;
      cnt_q <= '0;
    end else if (!hdx_en || line_active) begin
      dir_q <= DIR_TX;
      cnt_q <= '0;
    end else if (dir_q == DIR_TX && bit_tick) begin
      if (turn_done) begin
        dir_q <= DIR_RX;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign xcvr_tx = (dir_q == DIR_TX);
endmodule

// File: rtl/uart_tx_line_ctrl.sv
module uart_tx_line_ctrl #(
  parameter int BRK_W = 8,
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             brk_wr_en,
  input  logic [BRK_W-1:0] brk_wr_data,
  output logic [BRK_W-1:0] brk_rd_data,
  input  logic             dly_wr_en,
  input  logic [DLY_W-1:0] dly_wr_data,
  output logic [DLY_W-1:0] dly_rd_data,
  input  logic             hdx_en,
  input  logic             sh_busy,
  input  logic             sh_txd,
  input  logic             bit_tick,
  output logic             txd,
  output logic             xcvr_tx
);
  logic brk_req;
  logic brk_drive;
  logic line_active;

  uart_lc_regs #(.BRK_W(BRK_W), .DLY_W(DLY_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .brk_we    (brk_wr_en),
    .brk_wdata (brk_wr_data),
    .dly_we    (dly_wr_en),
    .dly_wdata (dly_wr_data),
    .brk_q     (brk_rd_data),
    .dly_q     (dly_rd_data),
    .brk_req   (brk_req)
  );

  uart_lc_break u_break (
    .clk       (clk),
    .rst       (rst),
    .brk_req   (brk_req),
    .sh_busy   (sh_busy),
    .sh_txd    (sh_txd),
    .brk_drive (brk_drive),
    .txd       (txd)
  );

  assign line_active = sh_busy | brk_drive;

  uart_lc_dir #(.DLY_W(DLY_W)) u_dir (
    .clk         (clk),
    .rst         (rst),
    .hdx_en      (hdx_en),
    .line_active (line_active),
    .bit_tick    (bit_tick),
    .dly         (dly_rd_data),
    .xcvr_tx     (xcvr_tx)
  );
endmodule

// File: rtl/uart_lc_checker.sv
module uart_lc_checker #(
  parameter int BRK_W = 8,
  parameter int DLY_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             brk_wr_en,
  input logic [BRK_W-1:0] brk_wr_data,
  input logic [BRK_W-1:0] brk_rd_data,
  input logic             dly_wr_en,
  input logic [DLY_W-1:0] dly_wr_data,
  input logic [DLY_W-1:0] dly_rd_data,
  input logic             hdx_en,
  input logic             sh_busy,
  input logic             sh_txd,
  input logic             bit_tick,
  input logic             txd,
  input logic             xcvr_tx
);
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (txd && !xcvr_tx && brk_rd_data == '0 && dly_rd_data == '0));

  p_brk_readback_r2: assert property (@(posedge clk) disable iff (rst)
    brk_wr_en |=> (brk_rd_data == $past(brk_wr_data)));

  p_dly_readback_r2: assert property (@(posedge clk) disable iff (rst)
    dly_wr_en |=> (dly_rd_data == $past(dly_wr_data)));

  p_break_low_r3: assert property (@(posedge clk) disable iff (rst)
    (brk_rd_data != '0 && !sh_busy) |=> !txd);

  p_release_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (brk_rd_data == '0 && !sh_busy) |=> txd);

  p_release_data_r4: assert property (@(posedge clk) disable iff (rst)
    (brk_rd_data == '0 && sh_busy) |=> (txd == $past(sh_txd)));

  p_defer_break_r5: assert property (@(posedge clk) disable iff (rst)
    ($rose(brk_rd_data != '0) && sh_busy) |=> (txd == $past(sh_txd)));

  p_full_duplex_r7: assert property (@(posedge clk) disable iff (rst)
    !hdx_en |=> xcvr_tx);

  p_busy_transmit_r8: assert property (@(posedge clk) disable iff (rst)
    sh_busy |=> xcvr_tx);

  p_rx_on_tick_r9: assert property (@(posedge clk) disable iff (rst)
    (xcvr_tx && !bit_tick) |=> xcvr_tx);

  p_break_transmit_r11: assert property (@(posedge clk) disable iff (rst)
    (brk_rd_data != '0 && !sh_busy) |=> xcvr_tx);
endmodule

bind uart_tx_line_ctrl uart_lc_checker #(.BRK_W(BRK_W), .DLY_W(DLY_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .brk_wr_en   (brk_wr_en),
  .brk_wr_data (brk_wr_data),
  .brk_rd_data (brk_rd_data),
  .dly_wr_en   (dly_wr_en),
  .dly_wr_data (dly_wr_data),
  .dly_rd_data (dly_rd_data),
  .hdx_en      (hdx_en),
  .sh_busy     (sh_busy),
  .sh_txd      (sh_txd),
  .bit_tick    (bit_tick),
  .txd         (txd),
  .xcvr_tx     (xcvr_tx)
);

// File: tb/tb_uart_tx_line_ctrl.sv
module tb_uart_tx_line_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       brk_wr_en = 1'b0;
  logic [7:0] brk_wr_data = '0;
  logic [7:0] brk_rd_data;
  logic       dly_wr_en = 1'b0;
  logic [3:0] dly_wr_data = '0;
  logic [3:0] dly_rd_data;
  logic       hdx_en = 1'b0;
  logic       sh_busy = 1'b0;
  logic       sh_txd = 1'b1;
  logic       bit_tick = 1'b0;
  logic       txd;
  logic       xcvr_tx;

  int checks = 0;
  int failures = 0;
  string cur_req = "R1";
  bit model_on = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  uart_tx_line_ctrl dut (
    .clk(clk), .rst(rst),
    .brk_wr_en(brk_wr_en), .brk_wr_data(brk_wr_data), .brk_rd_data(brk_rd_data),
    .dly_wr_en(dly_wr_en), .dly_wr_data(dly_wr_data), .dly_rd_data(dly_rd_data),
    .hdx_en(hdx_en), .sh_busy(sh_busy), .sh_txd(sh_txd), .bit_tick(bit_tick),
    .txd(txd), .xcvr_tx(xcvr_tx)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Bit-time tick: one pulse every 4 clocks.
  int tick_div = 0;
  always @(negedge clk) begin
    tick_div = (tick_div + 1) % 4;
    bit_tick <= (tick_div == 0);
  end

  // Reference model, advanced at each edge, compared 5 ns later.
  int  m_brk = 0, m_dly = 0, m_ticks = 0;
  bit  m_breaking = 0, m_txd = 1, m_dir = 0;
  always @(posedge clk) begin
    bit go_low;
    if (rst) begin
      m_brk = 0; m_dly = 0; m_ticks = 0;
      m_breaking = 0; m_txd = 1; m_dir = 0;
    end else begin
      if (m_brk == 0)       go_low = 0;
      else if (m_breaking)  go_low = 1;
      else                  go_low = !sh_busy;
      m_breaking = go_low;
      m_txd = go_low ? 1'b0 : (sh_busy ? sh_txd : 1'b1);
      if (!hdx_en || sh_busy || go_low) begin
        m_dir = 1; m_ticks = 0;
      end else if (m_dir && bit_tick) begin
        if (m_ticks >= m_dly) begin m_dir = 0; m_ticks = 0; end
        else m_ticks++;
      end
      if (brk_wr_en) m_brk = brk_wr_data;
      if (dly_wr_en) m_dly = dly_wr_data;
    end
    #5;
    if (model_on) begin
      check({cur_req, " txd"}, txd, m_txd);
      check({cur_req, " xcvr_tx"}, xcvr_tx, m_dir);
      check("R2 brk_rd_data", brk_rd_data, m_brk);
      check("R2 dly_rd_data", dly_rd_data, m_dly);
    end
  end

  task automatic wr_brk(input logic [7:0] v);
    @(negedge clk); brk_wr_en = 1'b1; brk_wr_data = v;
    @(negedge clk); brk_wr_en = 1'b0;
  endtask

  task automatic wr_dly(input logic [3:0] v);
    @(negedge clk); dly_wr_en = 1'b1; dly_wr_data = v;
    @(negedge clk); dly_wr_en = 1'b0;
  endtask

  task automatic send_char(input logic [7:0] d);
    logic [9:0] fr;
    fr = {1'b1, d, 1'b0};
    for (int b = 0; b < 10; b++) begin
      @(negedge clk); sh_busy = 1'b1; sh_txd = fr[b];
      repeat (3) @(negedge clk);
    end
    @(negedge clk); sh_busy = 1'b0; sh_txd = 1'b1;
  endtask

  // Counts ticks from the first idle edge until xcvr_tx falls.
  task automatic measure_turn(output int n);
    bit fell;
    n = 0; fell = 0;
    for (int i = 0; i < 300 && !fell; i++) begin
      @(posedge clk);
      if (bit_tick) n++;
      #5;
      if (!xcvr_tx) fell = 1;
    end
    if (!fell) n = -1;
  endtask

  initial begin
    int n;
    bit held;
    repeat (3) @(negedge clk);
    cur_req = "R1";
    check("R1 txd", txd, 1);
    check("R1 xcvr_tx", xcvr_tx, 0);
    check("R1 brk_rd_data", brk_rd_data, 0);
    check("R1 dly_rd_data", dly_rd_data, 0);
    rst = 1'b0;
    model_on = 1'b1;

    cur_req = "R2";
    wr_dly(4'h9);
    check("R2 dly readback", dly_rd_data, 9);

    cur_req = "R6";
    send_char(8'hA5);
    send_char(8'h3C);
    check("R6 idle txd", txd, 1);
    check("R7 full duplex xcvr_tx", xcvr_tx, 1);

    cur_req = "R3";
    wr_brk(8'h80);
    check("R2 brk readback", brk_rd_data, 8'h80);
    repeat (20) @(negedge clk);
    check("R3 break held", txd, 0);
    cur_req = "R4";
    wr_brk(8'h00);
    @(negedge clk);
    check("R4 released", txd, 1);

    cur_req = "R5";
    fork
      send_char(8'h5A);
      begin repeat (14) @(negedge clk); brk_wr_en = 1'b1; brk_wr_data = 8'h01;
            @(negedge clk); brk_wr_en = 1'b0; end
    join
    @(negedge clk);
    check("R5 break after char", txd, 0);
    cur_req = "R3";
    send_char(8'hFF);
    check("R3 break kept over busy", txd, 0);
    wr_brk(8'h00);
    repeat (2) @(negedge clk);

    cur_req = "R9";
    hdx_en = 1'b1;
    wr_dly(4'd3);
    send_char(8'h11);
    measure_turn(n);
    check("R9 ticks for D=3", n, 4);
    wr_dly(4'd0);
    send_char(8'h22);
    measure_turn(n);
    check("R9 ticks for D=0", n, 1);

    cur_req = "R10";
    wr_dly(4'd15);
    send_char(8'h33);
    held = 1;
    repeat (20) begin @(negedge clk); if (!xcvr_tx) held = 0; end
    check("R10 held before restart", held, 1);
    send_char(8'h44);
    measure_turn(n);
    check("R10 full count after restart", n, 16);

    cur_req = "R11";
    wr_dly(4'd2);
    wr_brk(8'h7E);
    held = 1;
    repeat (40) begin @(negedge clk); if (!xcvr_tx) held = 0; end
    check("R11 transmit during break", held, 1);
    check("R11 txd low", txd, 0);
    wr_brk(8'h00);
    measure_turn(n);
    check("R11 turn after break", n, 3);

    cur_req = "R12";
    wr_dly(4'd10);
    send_char(8'h55);
    n = 0;
    while (n < 3) begin @(posedge clk); if (bit_tick) n++; end
    wr_dly(4'd1);
    measure_turn(n);
    check("R12 lowered delay", n, 1);

    cur_req = "R7";
    hdx_en = 1'b0;
    repeat (2) @(negedge clk);
    check("R7 driver on", xcvr_tx, 1);

    cur_req = "R8";
    hdx_en = 1'b1;
    wr_dly(4'd0);
    repeat (12) @(negedge clk);
    check("R8 receive before char", xcvr_tx, 0);
    fork
      send_char(8'h0F);
      begin repeat (2) @(negedge clk); check("R8 transmit on busy", xcvr_tx, 1); end
    join

    cur_req = "R1";
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 reset xcvr_tx", xcvr_tx, 0);
    check("R1 reset dly", dly_rd_data, 0);
    repeat (4) @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule